// File: doc/BRIEF.md
# Masked Vector Merge Sequencer

This block builds a merged vector in a register file, one element at a time. A start pulse captures the operation: a vector length, a 64-bit mask, a polarity bit, a scalar-mode flag with a 64-bit scalar, and three register numbers for the first source, the second source and the destination. The block then steps through element indices from 0 upward. At each index it compares that index's mask bit with the polarity bit. On a match it writes the first operand: the element of the first source register, or the broadcast scalar in scalar mode. Otherwise it writes the element of the second source register. The destination element is written with the chosen value.

The register file sits outside the block. It has one shared element-index read port feeding two combinational read data buses, plus one synchronous write port. Each element is read and written in the same cycle, so the destination may be the same register as either source. A single-cycle done pulse tells the issuing logic that the merge has finished.

Top module: `vec_merge_seq`

## Requirements
- R1: After reset, busy, done and wrEn are all low.
- R2: A start pulse while idle performs one write per clock, with element indices 0, 1, 2 and so on, one after another. Every write targets the captured destination register, and the number of writes equals the captured length.
- R3: When mask bit i equals the polarity bit and scalar mode is off, element i of the first source register is written to element i of the destination.
- R4: When mask bit i differs from the polarity bit, element i of the second source register is written, in either mode.
- R5: In scalar mode, every element whose mask bit equals the polarity bit receives the same 64-bit scalar value.
- R6: Destination elements at indices at or above the captured length keep their previous contents.
- R7: A length of zero gives done in the cycle after start, with no write.
- R8: done is high for exactly one cycle, in the cycle after the last write. busy is high from the cycle after start through the done cycle.
- R9: The destination may equal either source. The result equals the merge of the register contents as they were before the operation.
- R10: A length above 64 is treated as 64.
- R11: All operation inputs are captured at start. A start or a change of inputs while busy has no effect on the running merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a merge (taken only while idle) |
| vecLen | input | 7 | Number of elements to process |
| maskBits | input | 64 | Per-element mask bits |
| polarity | input | 1 | Mask value that selects the first operand |
| scalarMode | input | 1 | First operand is the broadcast scalar |
| scalarVal | input | 64 | Broadcast scalar value |
| srcARegSel | input | 4 | First source register number |
| srcBRegSel | input | 4 | Second source register number |
| dstRegSel | input | 4 | Destination register number |
| busy | output | 1 | Merge in progress |
| done | output | 1 | One-cycle completion pulse |
| rdElemIdx | output | 6 | Element index for both reads |
| rdRegA | output | 4 | Register number for read bus A |
| rdRegB | output | 4 | Register number for read bus B |
| rdDataA | input | 64 | Element read from register A |
| rdDataB | input | 64 | Element read from register B |
| wrEn | output | 1 | Register file write strobe |
| wrReg | output | 4 | Destination register number |
| wrElemIdx | output | 6 | Destination element index |
| wrData | output | 64 | Value to write |

## Verification
The merge is run with both polarity values on the same irregular mask. A design that ignores or inverts the polarity therefore fails on exactly the complementary set of elements. Scalar mode is run against a mask with both bit values, so a broadcast is told apart from a vector read. Lengths of 0, 1, 5, 64 and 100 separate off-by-one errors in the end-of-run test, tail corruption and missing clamping. Aliased runs, with the destination equal to the first or the second source, show that each element is read before it is overwritten. A run with a second start and a flipped mask and polarity partway through shows that the inputs are captured at start.

// File: rtl/vm_pkg.sv
package vm_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } vmStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} vmState_t;
endpackage

// File: rtl/vm_ctrl.sv
module vm_ctrl
  import vm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lenZero,
  input  logic       isLast,
  output vmStrobe_t  strobe,
  output logic       busy,
  output logic       done
);
  vmState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = lenZero ? ST_FIN : ST_RUN;
      ST_RUN:  if (isLast) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
    busy        = (state != ST_IDLE);
    done        = (state == ST_FIN);
  end
endmodule

// File: rtl/vm_datapath.sv
module vm_datapath
  import vm_pkg::*;
#(
  parameter int ELEM_W  = 64,
  parameter int MAX_LEN = 64,
  parameter int REG_W   = 4,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  vmStrobe_t          strobe,
  input  logic [LEN_W-1:0]   vecLen,
  input  logic [MAX_LEN-1:0] maskBits,
  input  logic               polarity,
  input  logic               scalarMode,
  input  logic [ELEM_W-1:0]  scalarVal,
  input  logic [REG_W-1:0]   srcARegSel,
  input  logic [REG_W-1:0]   srcBRegSel,
  input  logic [REG_W-1:0]   dstRegSel,
  input  logic [ELEM_W-1:0]  rdDataA,
  input  logic [ELEM_W-1:0]  rdDataB,
  output logic               lenZero,
  output logic               isLast,
  output logic [IDX_W-1:0]   rdElemIdx,
  output logic [REG_W-1:0]   rdRegA,
  output logic [REG_W-1:0]   rdRegB,
  output logic               wrEn,
  output logic [REG_W-1:0]   wrReg,
  output logic [IDX_W-1:0]   wrElemIdx,
  output logic [ELEM_W-1:0]  wrData
);
  logic [LEN_W-1:0]   lenQ, lenClamped;
  logic [MAX_LEN-1:0] maskQ;
  logic               polQ, scalModeQ;
  logic [ELEM_W-1:0]  scalQ;
  logic [REG_W-1:0]   regAQ, regBQ, regCQ;
  logic [IDX_W-1:0]   idxQ;
  logic               pickFirst;

  assign lenClamped = (vecLen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vecLen;
  assign lenZero    = (vecLen == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ      <= '0;
      maskQ     <= '0;
      polQ      <= 1'b0;
      scalModeQ <= 1'b0;
      scalQ     <= '0;
      regAQ     <= '0;
      regBQ     <= '0;
      regCQ     <= '0;
      idxQ      <= '0;
    end else if (strobe.load) begin
      lenQ      <= lenClamped;
      maskQ     <= maskBits;
      polQ      <= polarity;
      scalModeQ <= scalarMode;
      scalQ     <= scalarVal;
      regAQ     <= srcARegSel;
      regBQ     <= srcBRegSel;
      regCQ     <= dstRegSel;
      idxQ      <= '0;
    end else if (strobe.step) begin
      idxQ <= idxQ + IDX_W'(1);
    end
  end

  assign isLast    = (({1'b0, idxQ} + LEN_W'(1)) == lenQ);
  assign pickFirst = (maskQ[idxQ] == polQ);

  assign rdElemIdx = idxQ;
  assign rdRegA    = regAQ;
  assign rdRegB    = regBQ;
  assign wrEn      = strobe.step;
  assign wrReg     = regCQ;
  assign wrElemIdx = idxQ;
  assign wrData    = pickFirst ? (scalModeQ ? scalQ : rdDataA) : rdDataB;
endmodule

// File: rtl/vec_merge_seq.sv
module vec_merge_seq
  import vm_pkg::*;
#(
  parameter int ELEM_W  = 64,
  parameter int MAX_LEN = 64,
  parameter int REG_W   = 4,
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LEN_W-1:0]   vecLen,
  input  logic [MAX_LEN-1:0] maskBits,
  input  logic               polarity,
  input  logic               scalarMode,
  input  logic [ELEM_W-1:0]  scalarVal,
  input  logic [REG_W-1:0]   srcARegSel,
  input  logic [REG_W-1:0]   srcBRegSel,
  input  logic [REG_W-1:0]   dstRegSel,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   rdElemIdx,
  output logic [REG_W-1:0]   rdRegA,
  output logic [REG_W-1:0]   rdRegB,
  input  logic [ELEM_W-1:0]  rdDataA,
  input  logic [ELEM_W-1:0]  rdDataB,
  output logic               wrEn,
  output logic [REG_W-1:0]   wrReg,
  output logic [IDX_W-1:0]   wrElemIdx,
  output logic [ELEM_W-1:0]  wrData
);
  vmStrobe_t strobe;
  logic      lenZero, isLast;

  vm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenZero(lenZero), .isLast(isLast),
    .strobe(strobe), .busy(busy), .done(done)
  );

  vm_datapath #(.ELEM_W(ELEM_W), .MAX_LEN(MAX_LEN), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecLen(vecLen), .maskBits(maskBits),
    .polarity(polarity), .scalarMode(scalarMode), .scalarVal(scalarVal),
    .srcARegSel(srcARegSel), .srcBRegSel(srcBRegSel), .dstRegSel(dstRegSel),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .lenZero(lenZero), .isLast(isLast),
    .rdElemIdx(rdElemIdx), .rdRegA(rdRegA), .rdRegB(rdRegB), .wrEn(wrEn),
    .wrReg(wrReg), .wrElemIdx(wrElemIdx), .wrData(wrData)
  );
endmodule

// File: rtl/vm_checker.sv
module vm_checker #(
  parameter int IDX_W = 6,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] vecLen,
  input logic             busy,
  input logic             done,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrElemIdx
);
  // R2
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  // R2
  first_index_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (!wrEn || wrElemIdx == '0));

  // R2
  index_ascends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> ((wrElemIdx - $past(wrElemIdx)) == IDX_W'(1)));

  // R7
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && vecLen == '0) |=> (done && !wrEn));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);
endmodule

bind vec_merge_seq vm_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .busy(busy),
  .done(done), .wrEn(wrEn), .wrElemIdx(wrElemIdx)
);

// File: tb/sim_vec_merge_seq.sv
module sim_vec_merge_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vecLen = '0;
  logic [63:0] maskBits = '0;
  logic        polarity = 1'b0;
  logic        scalarMode = 1'b0;
  logic [63:0] scalarVal = '0;
  logic [3:0]  srcARegSel = '0, srcBRegSel = '0, dstRegSel = '0;
  logic        busy, done, wrEn;
  logic [5:0]  rdElemIdx, wrElemIdx;
  logic [3:0]  rdRegA, rdRegB, wrReg;
  logic [63:0] rdDataA, rdDataB, wrData;

  logic [63:0] rf [16][64];

  typedef struct packed {
    logic [3:0]  reg_;
    logic [5:0]  idx;
    logic [63:0] data;
  } item_t;
  item_t expQ[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_merge_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .maskBits(maskBits),
    .polarity(polarity), .scalarMode(scalarMode), .scalarVal(scalarVal),
    .srcARegSel(srcARegSel), .srcBRegSel(srcBRegSel), .dstRegSel(dstRegSel),
    .busy(busy), .done(done), .rdElemIdx(rdElemIdx), .rdRegA(rdRegA),
    .rdRegB(rdRegB), .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn),
    .wrReg(wrReg), .wrElemIdx(wrElemIdx), .wrData(wrData)
  );

  assign rdDataA = rf[rdRegA][rdElemIdx];
  assign rdDataB = rf[rdRegB][rdElemIdx];

  always @(posedge clk) if (wrEn) rf[wrReg][wrElemIdx] <= wrData;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected writes as the design issues them
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (expQ.size() == 0) begin
        check(0, "R2/R6 unexpected write", {54'd0, wrElemIdx, wrReg}, 64'd0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        check(wrReg == e.reg_ && wrElemIdx == e.idx, "R2 write target",
              {54'd0, wrElemIdx, wrReg}, {54'd0, e.idx, e.reg_});
        check(wrData == e.data, "R3/R4/R5/R9 write data", wrData, e.data);
      end
    end
  end

  task automatic runOp(input int len, input logic [63:0] mask, input bit pol,
                       input bit scal, input logic [63:0] sval,
                       input int a, input int b, input int c, input bit disturb,
                       input string tag);
    logic [63:0] expReg [64];
    int effLen = (len > 64) ? 64 : len;
    int cyc = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < effLen) begin
        if (mask[i] == pol) expReg[i] = scal ? sval : rf[a][i];
        else                expReg[i] = rf[b][i];
        expQ.push_back('{reg_: 4'(c), idx: 6'(i), data: expReg[i]});
      end else begin
        expReg[i] = rf[c][i];
      end
    end
    @(negedge clk);
    start = 1'b1; vecLen = 7'(len); maskBits = mask; polarity = pol;
    scalarMode = scal; scalarVal = sval;
    srcARegSel = 4'(a); srcBRegSel = 4'(b); dstRegSel = 4'(c);
    do begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 2) begin
        // R11: restart attempt and changed inputs while busy
        start = 1'b1; maskBits = ~mask; polarity = ~pol; vecLen = 7'd3;
      end else begin
        start = 1'b0;
      end
    end while (!done && cyc < 200);
    // R7 R8 R10: done arrives effLen+1 cycles after start
    check(cyc == effLen + 1, {tag, " R8 done latency"}, 64'(cyc), 64'(effLen + 1));
    @(negedge clk);
    check(!done && !busy, {tag, " R8 done one cycle"}, {62'd0, done, busy}, 64'd0);
    check(expQ.size() == 0, {tag, " R2 write count"}, 64'(expQ.size()), 64'd0);
    expQ.delete();
    for (int i = 0; i < 64; i++)
      check(rf[c][i] == expReg[i], {tag, " R6/R9 dest contents"}, rf[c][i], expReg[i]);
  endtask

  initial begin
    for (int r = 0; r < 16; r++)
      for (int e = 0; e < 64; e++)
        rf[r][e] = {32'(r * 1000 + e), 32'hA5A5_0000 ^ 32'(e * 77 + r)};
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !wrEn, "R1 reset state", {61'd0, busy, done, wrEn}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wrEn, "R1 idle after reset", {61'd0, busy, done, wrEn}, 64'd0);

    runOp(64, 64'hF0F0_1234_8000_0001, 1'b1, 1'b0, 64'd0, 1, 2, 3, 1'b0, "R3 pol1");
    runOp(64, 64'hF0F0_1234_8000_0001, 1'b0, 1'b0, 64'd0, 1, 2, 4, 1'b0, "R4 pol0");
    runOp(64, 64'h0F0F_AAAA_5555_C3C3, 1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567,
          5, 6, 7, 1'b0, "R5 scalar");
    runOp(0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 64'd0, 1, 2, 8, 1'b0, "R7 zero");
    runOp(1, 64'h0, 1'b0, 1'b0, 64'd0, 9, 10, 11, 1'b0, "R2 len1");
    runOp(5, 64'h15, 1'b1, 1'b1, 64'h1111_2222_3333_4444, 2, 3, 12, 1'b0, "R6 len5");
    runOp(64, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, 64'd0, 13, 14, 13, 1'b0, "R9 dstA");
    runOp(40, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 64'd0, 1, 15, 15, 1'b0, "R9 dstB");
    runOp(100, 64'h8000_0000_0000_0003, 1'b1, 1'b0, 64'd0, 4, 5, 6, 1'b0, "R10 clamp");
    runOp(64, 64'h00FF_00FF_FF00_FF00, 1'b1, 1'b0, 64'd0, 7, 8, 9, 1'b1, "R11 busy");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule